// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Register Interface

This block is a slave register port for an external microcontroller that shares eight lines between address and data. Each bus cycle starts with an address phase. The address on the shared lines is taken when the address-latch strobe falls. A data phase follows, in which a register is read or written.

A static mode pin selects between two strobe conventions. With the pin low, the controller uses separate active-low read and write strobes. With the pin high, it uses one active-high data strobe together with a read/write direction line, where high means read. Every external strobe and the shared bus pass through two synchroniser flops into the internal clock domain, and edges are detected on the synchronised copies. The bidirectional lines are modelled as separate input, output and output-enable signals.

Behind the port is a small register file with nine byte-wide registers:
- Five control registers at 0x10 to 0x14.
- A test register at 0x15. Any nonzero value in it raises a test-enable output.
- Three signaling registers at 0x4D, 0x4E and 0x4F.

A state machine sequences each cycle through four states:
- IDLE: waits for the address-latch strobe to fall, then latches the address and moves to ADDR.
- ADDR: returns to IDLE if the address-latch strobe rises again. It moves to READ when a read strobe becomes active, or to WRITE when a write strobe becomes active.
- READ: drives the bus while the read strobe stays active. It returns to IDLE when the strobe ends.
- WRITE: returns to IDLE at the end of the write strobe, which is the write-strobe rise or the data-strobe fall. At that point it commits the byte on the bus. In data-strobe mode the commit happens only if the direction line still indicates a write.

Top module: `mbus_regif`

## Requirements
- R1: An active-high synchronous reset clears all nine registers to 0x00, clears `test_en` and deasserts `ad_oe`.
- R2: The register address is the value on `ad_in` when `ale` falls. Any later change of `ad_in` during that cycle does not change which register is accessed.
- R3: With `mode_ds` = 0, a write stores the value on `ad_in` at the rising edge of `wr_n` into the addressed register.
- R4: With `mode_ds` = 1, a write stores the value on `ad_in` at the falling edge of `ds` into the addressed register, provided `rnw` = 0 at that edge.
- R5: With `mode_ds` = 0, while `rd_n` is low after an address phase, `ad_oe` = 1 and `ad_out` holds the addressed register. After `rd_n` returns high, `ad_oe` = 0 and `ad_out` = 0x00.
- R6: With `mode_ds` = 1, while `ds` = 1 and `rnw` = 1 after an address phase, `ad_oe` = 1 and `ad_out` holds the addressed register. After `ds` falls, `ad_oe` returns to 0.
- R7: The register addresses are 0x10 to 0x14 for the control registers, 0x15 for the test register, and 0x4D to 0x4F for the signaling registers. Each address holds its own independent byte.
- R8: A read of any other address returns 0x00. A write to any other address changes no register.
- R9: `test_en` is 1 exactly when the test register at 0x15 holds a nonzero value.
- R10: When `mode_ds` = 1, the `rd_n` and `wr_n` inputs have no effect. They neither write a register nor enable the bus driver.
- R11: `ad_oe` is never 1 during a write cycle or while no read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_ds | input | 1 | Static mode pin: 0 = separate read/write strobes, 1 = data strobe with direction line |
| ale | input | 1 | Address-latch strobe; address taken on its falling edge |
| rd_n | input | 1 | Read strobe, active low (mode 0) |
| wr_n | input | 1 | Write strobe, active low (mode 0) |
| ds | input | 1 | Data strobe, active high (mode 1) |
| rnw | input | 1 | Direction line, 1 = read, 0 = write (mode 1) |
| ad_in | input | 8 | Shared address/data lines as seen by the block |
| ad_out | output | 8 | Read data driven toward the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| test_en | output | 1 | High when the test register is nonzero |

## Verification
A wrong latched address or a wrong state shows up on the first read that follows. The bus then returns a neighbouring register's byte or 0x00 a few clocks into the read strobe, or `ad_oe` stays low when it should be high. A write committed on the wrong edge, or under the wrong mode, leaves a stale or corrupted byte that the next readback of that register exposes. A driver that fails to release the bus shows as `ad_oe` still high about three clocks after the read strobe ends. A test register that holds the wrong value shows on `test_en` in the clock after the write commits.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } bus_state_t;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
    parameter int          W      = 8,
    parameter logic [W-1:0] IDLE_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= IDLE_V;
            stage2 <= IDLE_V;
        end else begin
            stage1 <= din;
            stage2 <= stage1;
        end
    end

    assign dout = stage2;
endmodule

// File: rtl/mbus_fsm.sv
module mbus_fsm
    import mbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_ds,
    input  logic          ale_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          ds_s,
    input  logic          rnw_s,
    input  logic [DW-1:0] ad_s,
    output logic [DW-1:0] addr_q,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          drive_en
);
    bus_state_t state, state_nx;
    logic ale_d, wr_n_d, ds_d;
    logic ale_fall, rd_act, wr_act, wr_stop;

    always_comb begin
        ale_fall = ale_d & ~ale_s;
        rd_act   = mode_ds ? (ds_s & rnw_s)  : ~rd_n_s;
        wr_act   = mode_ds ? (ds_s & ~rnw_s) : ~wr_n_s;
        wr_stop  = mode_ds ? (ds_d & ~ds_s)  : (~wr_n_d & wr_n_s);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (ale_fall) state_nx = ST_ADDR;
            ST_ADDR: begin
                if (ale_s)       state_nx = ST_IDLE;
                else if (rd_act) state_nx = ST_READ;
                else if (wr_act) state_nx = ST_WRITE;
            end
            ST_READ:  if (!rd_act) state_nx = ST_IDLE;
            ST_WRITE: if (wr_stop) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            ale_d  <= 1'b0;
            wr_n_d <= 1'b1;
            ds_d   <= 1'b0;
        end else begin
            state  <= state_nx;
            ale_d  <= ale_s;
            wr_n_d <= wr_n_s;
            ds_d   <= ds_s;
            if (state == ST_IDLE && ale_fall)
                addr_q <= ad_s;
        end
    end

    always_comb begin
        drive_en = (state == ST_READ);
        wr_en    = (state == ST_WRITE) && wr_stop && (!mode_ds || !rnw_s);
        wr_data  = ad_s;
    end

    // R3 / R4: a write commit is a single-cycle event per strobe
    assert_wr_single_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R11: driver enabled only when a read strobe was active the cycle before
    assert_oe_after_read_R11: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> $past(rd_act));
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile #(
    parameter int           DW        = 8,
    parameter logic [7:0]   CTRL_BASE = 8'h10,
    parameter int           CTRL_NUM  = 6,
    parameter int           TEST_IDX  = 5,
    parameter logic [7:0]   SIG_BASE  = 8'h4D,
    parameter int           SIG_NUM   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          test_en
);
    localparam int TOTAL = CTRL_NUM + SIG_NUM;

    logic [DW-1:0]       regs_q [TOTAL];
    logic [TOTAL-1:0]    hit_vec;
    logic [TOTAL*DW-1:0] flat;
    logic                any_hit;

    for (genvar i = 0; i < TOTAL; i++) begin : g_reg
        localparam logic [7:0] ADR = (i < CTRL_NUM) ? CTRL_BASE + 8'(i)
                                                     : SIG_BASE + 8'(i - CTRL_NUM);
        assign hit_vec[i] = (addr == ADR);
        assign flat[i*DW +: DW] = regs_q[i];
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[i] <= '0;
            else if (wr_en && hit_vec[i])
                regs_q[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < TOTAL; k++)
            if (hit_vec[k]) rd_data = regs_q[k];
    end

    assign any_hit = |hit_vec;
    assign test_en = |regs_q[TEST_IDX];

    // R1: the cycle after reset every register is zero
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flat == '0));

    // R8: unmapped writes leave the whole file unchanged
    assert_unmapped_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !any_hit) |=> $stable(flat));

    // R9: test flag follows the value written to the test register
    assert_test_flag_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit_vec[TEST_IDX]) |=> (test_en == ($past(wr_data) != '0)));
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_ds,
    input  logic          ale,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ds,
    input  logic          rnw,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          test_en
);
    localparam int SW = DW + 5;
    localparam logic [SW-1:0] SYNC_IDLE = {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, {DW{1'b0}}};

    logic [SW-1:0] raw_v, sync_v;
    logic          ale_s, rd_n_s, wr_n_s, ds_s, rnw_s;
    logic [DW-1:0] ad_s, addr_q, wr_data, rd_data;
    logic          wr_en, drive_en;

    assign raw_v = {ale, rd_n, wr_n, ds, rnw, ad_in};
    assign {ale_s, rd_n_s, wr_n_s, ds_s, rnw_s, ad_s} = sync_v;

    mbus_sync #(.W(SW), .IDLE_V(SYNC_IDLE)) u_sync (
        .clk(clk), .rst(rst), .din(raw_v), .dout(sync_v)
    );

    mbus_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst(rst), .mode_ds(mode_ds),
        .ale_s(ale_s), .rd_n_s(rd_n_s), .wr_n_s(wr_n_s),
        .ds_s(ds_s), .rnw_s(rnw_s), .ad_s(ad_s),
        .addr_q(addr_q), .wr_en(wr_en), .wr_data(wr_data), .drive_en(drive_en)
    );

    mbus_regfile #(.DW(DW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr_q[7:0]),
        .wr_data(wr_data), .rd_data(rd_data), .test_en(test_en)
    );

    assign ad_oe  = drive_en;
    assign ad_out = drive_en ? rd_data : '0;

    // R11: driver never on while a write commit happens
    assert_no_drive_on_write_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !ad_oe);
endmodule

// File: tb/mbus_regif_tb.sv
module mbus_regif_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_ds = 1'b0;
    logic       ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, ds = 1'b0, rnw = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [7:0] ad_out;
    logic       ad_oe, test_en;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    mbus_regif u_dut (
        .clk(clk), .rst(rst), .mode_ds(mode_ds), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .ds(ds), .rnw(rnw), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .test_en(test_en)
    );

    localparam logic [7:0] MAP [9] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h14,
                                       8'h15, 8'h4D, 8'h4E, 8'h4F};
    logic [7:0] model [9];

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        ad_in = a; ale = 1'b1; cyc(3);
        ale = 1'b0; cyc(4);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input string req);
        addr_phase(a);
        ad_in = d;
        if (mode_ds) begin rnw = 1'b0; ds = 1'b1; end
        else wr_n = 1'b0;
        cyc(4);
        chk({7'd0, ad_oe}, 8'h00, {req, " R11 oe during write"});
        if (mode_ds) ds = 1'b0; else wr_n = 1'b1;
        cyc(4);
        rnw = 1'b1; ad_in = 8'hEE;
        cyc(2);
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr_phase(a);
        ad_in = ~a;  // R2: bus changes after address latch
        if (mode_ds) begin rnw = 1'b1; ds = 1'b1; end
        else rd_n = 1'b0;
        cyc(5);
        chk({7'd0, ad_oe}, 8'h01, {req, " oe during read"});
        chk(ad_out, exp, {req, " read data"});
        if (mode_ds) ds = 1'b0; else rd_n = 1'b1;
        cyc(5);
        chk({7'd0, ad_oe}, 8'h00, {req, " oe released"});
        chk(ad_out, 8'h00, {req, " out released"});
    endtask

    task automatic do_reset;
        rst = 1'b1; cyc(4); rst = 1'b0; cyc(2);
        foreach (model[i]) model[i] = 8'h00;
    endtask

    task automatic t_reset_state;
        chk({7'd0, ad_oe}, 8'h00, "R1 oe after reset");
        chk({7'd0, test_en}, 8'h00, "R1 test_en after reset");
        for (int i = 0; i < 9; i++) bus_read(MAP[i], 8'h00, "R1");
    endtask

    task automatic t_mode0_map;
        mode_ds = 1'b0; cyc(2);
        for (int i = 0; i < 9; i++) begin
            if (i == 5) continue;
            model[i] = 8'hA0 + 8'(i * 7);
            bus_write(MAP[i], model[i], "R3");
        end
        for (int i = 0; i < 9; i++) bus_read(MAP[i], model[i], "R7 R5 R2");
    endtask

    task automatic t_mode1;
        mode_ds = 1'b1; cyc(2);
        model[0] = 8'h3C; bus_write(MAP[0], model[0], "R4");
        model[8] = 8'hC3; bus_write(MAP[8], model[8], "R4");
        bus_read(MAP[0], 8'h3C, "R4 R6");
        bus_read(MAP[8], 8'hC3, "R4 R6");
        bus_read(MAP[4], model[4], "R6");
    endtask

    task automatic t_unmapped;
        bus_write(8'h20, 8'hFF, "R8");
        bus_write(8'h4C, 8'hFF, "R8");
        bus_write(8'h50, 8'hFF, "R8");
        bus_read(8'h4C, 8'h00, "R8 unmapped read");
        bus_read(8'h16, 8'h00, "R8 unmapped read");
        for (int i = 0; i < 9; i++) bus_read(MAP[i], model[i], "R8 neighbours kept");
    endtask

    task automatic t_test_reg;
        bus_write(8'h15, 8'h01, "R9");
        chk({7'd0, test_en}, 8'h01, "R9 test_en set");
        bus_read(8'h15, 8'h01, "R9 readback");
        bus_write(8'h15, 8'h00, "R9");
        chk({7'd0, test_en}, 8'h00, "R9 test_en clear");
    endtask

    task automatic t_wrong_mode;
        mode_ds = 1'b1; cyc(2);
        addr_phase(8'h10);
        ad_in = 8'h77;
        wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(4);
        rd_n = 1'b0; cyc(5);
        chk({7'd0, ad_oe}, 8'h00, "R10 rd_n ignored in mode 1");
        rd_n = 1'b1; cyc(2);
        ale = 1'b1; cyc(4); ale = 1'b0; cyc(4);
        bus_read(8'h10, model[0], "R10 wr_n ignored in mode 1");
    endtask

    initial begin
        foreach (model[i]) model[i] = 8'h00;
        cyc(1);
        do_reset();
        t_reset_state();
        t_mode0_map();
        t_mode1();
        t_unmapped();
        t_test_reg();
        t_wrong_mode();
        bus_write(8'h15, 8'h5A, "R9");
        do_reset();
        chk({7'd0, test_en}, 8'h00, "R1 test_en after mid-run reset");
        mode_ds = 1'b0; cyc(2);
        bus_read(8'h12, 8'h00, "R1 mid-run reset");
        bus_read(8'h4E, 8'h00, "R1 mid-run reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule